// File: doc/BRIEF.md
# I2C Register-Access Target

This block lets an external I2C master read and write a small bank of 8-bit registers. The registers themselves sit outside the block, behind a parallel port made of an address, write data, a single-cycle write strobe and an asynchronous read-data input. The block runs on a system clock that is much faster than SCL. It takes SCL and SDA as lines that are already synchronized, and it pulls SDA low through an output enable, so the bus stays open-drain.

A write transaction carries the device address with R/W = 0, then a sub-address byte that loads the register pointer, then any number of data bytes. These bytes land in consecutive registers. A read uses the combined format. A write-format phase sets the pointer, and then a START or repeated START is followed by the address with R/W = 1, after which the target streams bytes from the pointer. The pointer survives STOP and repeated START, so a read that has no sub-address phase continues from where the last burst left off. One bit of the device address comes from a strap input.

Top module: `i2c_reg_target`

## Requirements
- R1: While reset is asserted and right after it, `sda_oe_o` and `reg_we_o` are both low.
- R2: The device address is `BASE_ADDR` (default 7'h50) with bit `SEL_BIT` (default 1) replaced by `addr_sel_i`. The master sends it MSB first, and the R/W bit follows it as the eighth bit. When the address matches, the target pulls SDA low during the ninth clock.
- R3: When the address does not match, the target never pulls SDA low and never asserts `reg_we_o` until the next START.
- R4: In a write, the first byte after the address is the sub-address, and its low `REG_AW` bits load the pointer. Each following byte gives one `reg_we_o` pulse with the pointer on `reg_addr_o`, and then the pointer increments. The target ACKs the sub-address byte and every data byte.
- R5: The pointer wraps modulo 2^`REG_AW` in both write and read bursts.
- R6: After an address with R/W = 1, the target drives `reg_rdata_i` at the pointer MSB first. The pointer increments after each byte it sends.
- R7: A master NACK ends a read and SDA stays released. After a STOP, `sda_oe_o` is low on the next clock.
- R8: The pointer keeps its value across STOP and across a repeated START. A read with no sub-address phase starts from it.
- R9: `sda_oe_o` changes only after a clock in which SCL was low. `reg_we_o` lasts exactly one clock and is asserted only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL |
| sda_i | input | 1 | Synchronized SDA (bus level) |
| addr_sel_i | input | 1 | Strap value for the selectable address bit |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_addr_o | output | REG_AW | Register pointer |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Read data at `reg_addr_o` |

## Verification
The assertions check on every clock that the SDA enable moves only after SCL was low, that the write strobe is a single clock wide inside the SCL low phase, and that a STOP leaves SDA released. Address matching against the strap, silence toward foreign addresses, pointer wrap, and the pointer surviving STOP and repeated START all depend on whole transactions. Only the bench's scenarios can show these, and it compares read data against a model it keeps of what it wrote.

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0] BASE_ADDR = 7'h50,
  parameter int SEL_BIT = 1,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_oe_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [7:0]        reg_wdata_o,
  output logic              reg_we_o,
  input  logic [7:0]        reg_rdata_i
);
  typedef enum logic [2:0] {M_IDLE, M_DEV, M_SUB, M_WR, M_RDW, M_RD} mode_t;

  mode_t             mode;
  logic              scl_q, sda_q, oe;
  logic [3:0]        bitcnt;
  logic [7:0]        rx, tx;
  logic [REG_AW-1:0] ptr;
  logic [6:0]        my_addr;

  assign my_addr = (BASE_ADDR & ~(7'd1 << SEL_BIT)) | (7'(addr_sel_i) << SEL_BIT);

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire byte_end = scl_fall && bitcnt == 4'd8;

  assign reg_we_o    = byte_end && mode == M_WR && !start_c && !stop_c;
  assign reg_wdata_o = rx;
  assign reg_addr_o  = ptr;
  assign sda_oe_o    = oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= M_IDLE;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      oe     <= 1'b0;
      bitcnt <= '0;
      rx     <= '0;
      tx     <= '0;
      ptr    <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_c) begin
        mode   <= M_DEV;
        bitcnt <= '0;
        oe     <= 1'b0;
      end else if (stop_c) begin
        mode <= M_IDLE;
        oe   <= 1'b0;
      end else if (mode != M_IDLE) begin
        if (scl_rise) begin
          if (bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (mode == M_RD) begin
              ptr <= ptr + 1'b1;
              if (sda_i) mode <= M_IDLE;
            end
          end else begin
            bitcnt <= bitcnt + 4'd1;
            rx     <= {rx[6:0], sda_i};
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            case (mode)
              M_DEV: begin
                if (rx[7:1] == my_addr) begin
                  oe   <= 1'b1;
                  mode <= rx[0] ? M_RDW : M_SUB;
                end else begin
                  mode <= M_IDLE;
                end
              end
              M_SUB: begin
                ptr  <= rx[REG_AW-1:0];
                oe   <= 1'b1;
                mode <= M_WR;
              end
              M_WR: begin
                ptr <= ptr + 1'b1;
                oe  <= 1'b1;
              end
              default: oe <= 1'b0;
            endcase
          end else if (bitcnt == 4'd0) begin
            if (mode == M_RD || mode == M_RDW) begin
              oe   <= ~reg_rdata_i[7];
              tx   <= {reg_rdata_i[6:0], 1'b0};
              mode <= M_RD;
            end else begin
              oe <= 1'b0;
            end
          end else if (mode == M_RD) begin
            oe <= ~tx[7];
            tx <= {tx[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

module i2c_reg_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_i,
  input logic sda_oe_o,
  input logic reg_we_o
);
  a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !$past(scl_i));

  a_r9_we_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);

  a_r9_we_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> !scl_i);

  a_r7_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> !sda_oe_o);
endmodule

bind i2c_reg_target i2c_reg_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
  .sda_oe_o(sda_oe_o), .reg_we_o(reg_we_o)
);

// File: tb/i2c_reg_target_tb_top.sv
`timescale 1ns/1ps
module i2c_reg_target_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, sel_m = 1'b0;
  logic sda_oe;
  logic [3:0] raddr;
  logic [7:0] wdata, rdata;
  logic we;
  logic [7:0] regs [16];
  logic [7:0] expv [16];
  int n_chk = 0, n_bad = 0, we_cnt = 0;
  logic oe_seen = 1'b0;
  wire sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_reg_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(sel_m), .sda_oe_o(sda_oe), .reg_addr_o(raddr),
    .reg_wdata_o(wdata), .reg_we_o(we), .reg_rdata_i(rdata)
  );

  assign rdata = regs[raddr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] <= 8'h00;
    end else if (we) begin
      regs[raddr] <= wdata;
      we_cnt <= we_cnt + 1;
    end
    if (sda_oe) oe_seen <= 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic start_c();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = sda_bus; q(); scl_m = 1'b0; q();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic more);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    wbit(~more);
  endtask

  logic ack;
  logic [7:0] d;
  logic [6:0] match_a;
  int w0;
  int p;

  initial begin
    repeat (5) @(posedge clk);
    #1;
    chk("R1 oe in reset", sda_oe, 0);
    chk("R1 we in reset", we, 0);
    rst_n = 1'b1;
    q();
    chk("R1 oe after reset", sda_oe, 0);
    chk("R1 we after reset", we, 0);

    // R2 / R3: sweep all addresses for both strap values
    for (int s = 0; s < 2; s++) begin
      sel_m = s[0];
      match_a = 7'h50 | (7'(s) << 1);
      for (int a = 0; a < 128; a++) begin
        start_c();
        wbyte({a[6:0], 1'b0}, ack);
        stop_c();
        chk(a[6:0] == match_a ? "R2 ack on match" : "R3 silent on mismatch", ack, a[6:0] == match_a);
      end
    end
    chk("R3 no write during sweep", we_cnt, 0);
    sel_m = 1'b0;

    // R3: foreign address followed by bytes
    w0 = we_cnt;
    oe_seen = 1'b0;
    start_c();
    wbyte(8'hA4, ack); chk("R3 no addr ack", ack, 0);
    wbyte(8'h03, ack); chk("R3 no sub ack", ack, 0);
    wbyte(8'h00, ack); chk("R3 no data ack", ack, 0);
    stop_c();
    chk("R3 no write", we_cnt, w0);
    chk("R3 never drove sda", oe_seen, 0);

    // R4: fill all registers in one burst
    w0 = we_cnt;
    start_c();
    wbyte(8'hA0, ack); chk("R2 write addr ack", ack, 1);
    wbyte(8'h00, ack); chk("R4 sub ack", ack, 1);
    for (int i = 0; i < 16; i++) begin
      expv[i] = 8'(i * 37 + 5);
      wbyte(expv[i], ack);
      chk("R4 data ack", ack, 1);
    end
    stop_c();
    chk("R4 one strobe per byte", we_cnt - w0, 16);
    for (int i = 0; i < 16; i++) chk("R4 register content", regs[i], expv[i]);

    // R6 / R8: combined read with repeated START from 0, full bank
    start_c();
    wbyte(8'hA0, ack);
    wbyte(8'h00, ack);
    start_c();
    wbyte(8'hA1, ack); chk("R2 read addr ack", ack, 1);
    for (int i = 0; i < 16; i++) begin
      rbyte(d, i != 15);
      chk("R6 read data", d, expv[i]);
    end
    stop_c();
    chk("R7 released after stop", sda_oe, 0);

    // R5: write burst wrapping past the top
    start_c();
    wbyte(8'hA0, ack);
    wbyte(8'h0E, ack);
    for (int k = 0; k < 4; k++) begin
      p = (14 + k) % 16;
      expv[p] = 8'(8'hC0 + k);
      wbyte(expv[p], ack);
    end
    stop_c();
    for (int k = 0; k < 4; k++) chk("R5 wrapped write", regs[(14 + k) % 16], expv[(14 + k) % 16]);

    // R8: read with STOP between phases, wrapping (R5)
    start_c();
    wbyte(8'hA0, ack);
    wbyte(8'h0E, ack);
    stop_c();
    start_c();
    wbyte(8'hA1, ack);
    for (int k = 0; k < 4; k++) begin
      rbyte(d, k != 3);
      chk("R5 wrapped read", d, expv[(14 + k) % 16]);
    end
    stop_c();
    chk("R7 released after nack", sda_oe, 0);

    // R8: read with no sub-address resumes at 14+4 = 2
    start_c();
    wbyte(8'hA1, ack);
    rbyte(d, 1'b1); chk("R8 resume pointer", d, expv[2]);
    rbyte(d, 1'b0); chk("R6 pointer incremented", d, expv[3]);
    stop_c();

    // R8: write sub 5 plus two bytes, repeated START read gives reg 7
    start_c();
    wbyte(8'hA0, ack);
    wbyte(8'h05, ack);
    expv[5] = 8'h3C; wbyte(expv[5], ack);
    expv[6] = 8'h81; wbyte(expv[6], ack);
    start_c();
    wbyte(8'hA1, ack);
    rbyte(d, 1'b0);
    chk("R8 pointer across repeated start", d, expv[7]);
    stop_c();
    chk("R4 register 5", regs[5], 8'h3C);
    chk("R4 register 6", regs[6], 8'h81);

    // R2: strap at 1 moves the device to 0x52
    sel_m = 1'b1;
    start_c();
    wbyte(8'hA4, ack); chk("R2 strap address ack", ack, 1);
    wbyte(8'h09, ack);
    expv[9] = 8'h5A; wbyte(expv[9], ack);
    stop_c();
    chk("R2 strap write", regs[9], 8'h5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule